// File: doc/BRIEF.md
# One-Time-Programmable Fuse Array Controller

This block sits between a simple register bus and a small array of one-time-programmable fuse words, each 32 bits wide. The fuse cells are modelled as flops that start at zero and are never cleared by reset. Software programs a word by writing to a word-addressed window. Reading the same window returns the fuse contents. Programming only happens when three separate guards are all open: a key value held in a key register, a two-key supply switch together with a program enable, and a per-word permanent lock that must not yet be set.

Optional features are chosen through a control register. A doubled mode writes every programmed bit into a primary copy and a backup copy. Doubled reads combine the two copies, either leniently by OR or strictly by AND when the margin mode is on. An auto-check mode senses the word again while it is being programmed and raises a flag if the intended ones are not seen. All rejected or faulty accesses set bits in a 14-bit error register, which software clears by writing ones.

The bus has no back-pressure. Every request is taken in the cycle that `bus_req` is high. A read returns its data one cycle later, marked by `bus_rvalid`. Register fields and the window start are placed at fixed byte offsets.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: Reset clears every register (control, error, key, config word, supply switch) to zero and drops `bus_rvalid`; a read request returns its data with `bus_rvalid` high on the next cycle.
- R2: Register offsets: control at 0x20, error at 0x24, error clear at 0x28, key at 0x2C, config word at 0x50, supply switch at 0x54, fuse word N at 0x1000 + 4*N. Control bits are bit0 read power, bit1 auto-check, bit2 doubling, bit3 margin, bit4 lock-write, and read back as written with the upper bits zero. Supply bits are bit0 key one, bit1 key two, bit2 program enable. The key register and the config word read back all 32 bits.
- R3: A window write programs only when the key register holds 0x00008810 and program enable is set. Otherwise it changes nothing and sets error bit0. Programming is OR-only: a one bit sets a fuse and a zero bit leaves it unchanged.
- R4: With the key and program enable correct, the supply is valid only when key one is 1 and key two is 0. In any other key state the write changes nothing and sets error bit1.
- R5: A gated write while lock-write is set locks that word whatever the data, and leaves its contents unchanged. A later program of a locked word changes nothing and sets error bit2. Locks and fuse contents survive reset.
- R6: A program with doubling set ORs the data into both the primary and the backup copy. Without doubling, only the primary copy changes. A read without doubling returns the primary copy, and a doubled read without margin returns primary OR backup.
- R7: A doubled read with margin set returns primary AND backup. Margin alone, without doubling, has no effect.
- R8: With auto-check set, a program senses the word through the read path. If read power is clear, the sensed word is zero, so any nonzero data sets error bit3. The fuses are programmed anyway. With read power set, no flag is raised.
- R9: A window read while read power is clear returns zero and sets error bit4.
- R10: A window access to a word at or beyond the parameterised word count reads zero, programs nothing and sets error bit5.
- R11: Writing a mask to the error clear offset clears exactly the matching error bits. A read of the clear offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, taken in the cycle it is high |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High one cycle after a read request |

## Verification
The bench builds the block with a word count of 12 instead of the default 96. This puts both the last real word (11) and the first missing word (12) a few bus cycles away, and it keeps the non-power-of-two index path in play. A mid-run reset shows that locks and fuse values survive while registers clear. Doubled and margin reads are used on a word that holds primary-only bits next to doubled bits, so the AND read exposes the backup copy.

// File: rtl/otp_pkg.sv
package otp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ERR_W  = 14;

  localparam logic [15:0] OFS_CTRL  = 16'h0020;
  localparam logic [15:0] OFS_ERR   = 16'h0024;
  localparam logic [15:0] OFS_CLR   = 16'h0028;
  localparam logic [15:0] OFS_KEY   = 16'h002C;
  localparam logic [15:0] OFS_CFG   = 16'h0050;
  localparam logic [15:0] OFS_SUPPLY = 16'h0054;
  localparam logic [15:0] OFS_WIN   = 16'h1000;

  localparam logic [WORD_W-1:0] KEY_VALUE = 32'h0000_8810;

  localparam int unsigned E_GATE   = 0;
  localparam int unsigned E_SUPPLY = 1;
  localparam int unsigned E_LOCKED = 2;
  localparam int unsigned E_CHECK  = 3;
  localparam int unsigned E_NOPWR  = 4;
  localparam int unsigned E_RANGE  = 5;

  typedef struct packed {
    logic lock_wr;
    logic margin;
    logic dbl;
    logic check;
    logic rd_pwr;
  } ctrl_t;

  typedef struct packed {
    logic prog;
    logic key2;
    logic key1;
  } supply_t;
endpackage

// File: rtl/otp_regs.sv
module otp_regs import otp_pkg::*; #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ERR_W-1:0]  err_set,
  output ctrl_t             ctrl,
  output supply_t           supply,
  output logic              key_ok,
  output logic [ERR_W-1:0]  err_q,
  output logic [WORD_W-1:0] reg_rdata
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam int unsigned SUP_W  = $bits(supply_t);

  logic              wr;
  logic [WORD_W-1:0] key_q, cfg_q;
  logic [ERR_W-1:0]  clr_mask;

  assign wr       = req && we;
  assign clr_mask = (wr && addr == ADDR_W'(OFS_CLR)) ? wdata[ERR_W-1:0] : '0;
  assign key_ok   = (key_q == KEY_VALUE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      supply <= '0;
      key_q  <= '0;
      cfg_q  <= '0;
      err_q  <= '0;
    end else begin
      if (wr && addr == ADDR_W'(OFS_CTRL))   ctrl   <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr && addr == ADDR_W'(OFS_SUPPLY)) supply <= supply_t'(wdata[SUP_W-1:0]);
      if (wr && addr == ADDR_W'(OFS_KEY))    key_q  <= wdata;
      if (wr && addr == ADDR_W'(OFS_CFG))    cfg_q  <= wdata;
      err_q <= (err_q & ~clr_mask) | err_set;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (addr == ADDR_W'(OFS_CTRL))   reg_rdata = WORD_W'(ctrl);
    if (addr == ADDR_W'(OFS_ERR))    reg_rdata = WORD_W'(err_q);
    if (addr == ADDR_W'(OFS_KEY))    reg_rdata = key_q;
    if (addr == ADDR_W'(OFS_CFG))    reg_rdata = cfg_q;
    if (addr == ADDR_W'(OFS_SUPPLY)) reg_rdata = WORD_W'(supply);
  end

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_mask != '0 && err_set == '0) |=> ((err_q & $past(clr_mask)) == '0));
endmodule

// File: rtl/otp_gate.sv
module otp_gate import otp_pkg::*; (
  input  logic              wr_win,
  input  logic              rd_win,
  input  logic              rng_err,
  input  logic              rd_pwr,
  input  logic              check,
  input  logic              lock_wr,
  input  supply_t           supply,
  input  logic              key_ok,
  input  logic              blk_locked,
  input  logic [WORD_W-1:0] cur_word,
  input  logic [WORD_W-1:0] wdata,
  output logic              do_prog,
  output logic              do_lock,
  output logic [ERR_W-1:0]  err_set
);
  logic [WORD_W-1:0] sensed;

  always_comb begin
    do_prog = 1'b0;
    do_lock = 1'b0;
    err_set = '0;
    sensed  = '0;
    if (rng_err) err_set[E_RANGE] = 1'b1;
    if (rd_win && !rd_pwr) err_set[E_NOPWR] = 1'b1;
    if (wr_win) begin
      if (!(key_ok && supply.prog))          err_set[E_GATE]   = 1'b1;
      else if (!(supply.key1 && !supply.key2)) err_set[E_SUPPLY] = 1'b1;
      else if (lock_wr)                      do_lock = 1'b1;
      else if (blk_locked)                   err_set[E_LOCKED] = 1'b1;
      else begin
        do_prog = 1'b1;
        if (check) begin
          sensed = rd_pwr ? (cur_word | wdata) : '0;
          if ((sensed & wdata) != wdata) err_set[E_CHECK] = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/otp_array.sv
module otp_array import otp_pkg::*; #(
  parameter int unsigned NUM_BLK = 96,
  parameter int unsigned IDX_W   = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog,
  input  logic              lock,
  input  logic              dbl,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] prim_word,
  output logic [WORD_W-1:0] red_word,
  output logic              locked
);
  logic [WORD_W-1:0]  prim_arr [NUM_BLK];
  logic [WORD_W-1:0]  red_arr  [NUM_BLK];
  logic [NUM_BLK-1:0] lock_vec;

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_word
    logic [WORD_W-1:0] p_q = '0;
    logic [WORD_W-1:0] r_q = '0;
    logic              l_q = 1'b0;
    logic              hit;
    assign hit = (idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (prog && hit) begin
        p_q <= p_q | wdata;
        if (dbl) r_q <= r_q | wdata;
      end
      if (lock && hit) l_q <= 1'b1;
    end
    assign prim_arr[g]  = p_q;
    assign red_arr[g]   = r_q;
    assign lock_vec[g]  = l_q;
  end

  assign prim_word = prim_arr[idx];
  assign red_word  = red_arr[idx];
  assign locked    = lock_vec[idx];

  // R3
  prog_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog |=> ((prim_arr[$past(idx)] & $past(wdata)) == $past(wdata)));
  // R5
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lock_vec) & ~lock_vec) == '0));
  // R5
  locked_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog && locked));
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl import otp_pkg::*; #(
  parameter int unsigned NUM_BLK = 96,
  parameter int unsigned ADDR_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid
);
  localparam int unsigned IDX_W = $clog2(NUM_BLK);
  localparam int unsigned OFF_W = ADDR_W - 2;
  localparam logic [OFF_W-1:0] LAST_IDX = OFF_W'(NUM_BLK - 1);

  ctrl_t             ctrl;
  supply_t           supply;
  logic              key_ok, win_hit, in_rng, wr_win, rd_win, rng_err;
  logic              do_prog, do_lock, locked;
  logic [ADDR_W-1:0] win_off;
  logic [OFF_W-1:0]  full_idx;
  logic [IDX_W-1:0]  idx;
  logic [ERR_W-1:0]  err_set, err_q;
  logic [WORD_W-1:0] reg_rdata, prim_word, red_word, sensed_word, win_word;
  logic [1:0]        unused_lsb;

  assign win_hit    = bus_addr >= ADDR_W'(OFS_WIN);
  assign win_off    = bus_addr - ADDR_W'(OFS_WIN);
  assign full_idx   = win_off[ADDR_W-1:2];
  assign unused_lsb = win_off[1:0];
  assign in_rng     = full_idx <= LAST_IDX;
  assign idx        = full_idx[IDX_W-1:0];
  assign wr_win     = bus_req && bus_we && win_hit && in_rng;
  assign rd_win     = bus_req && !bus_we && win_hit && in_rng;
  assign rng_err    = bus_req && win_hit && !in_rng;

  otp_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .req(bus_req), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .err_set(err_set), .ctrl(ctrl), .supply(supply),
    .key_ok(key_ok), .err_q(err_q), .reg_rdata(reg_rdata)
  );

  otp_array #(.NUM_BLK(NUM_BLK), .IDX_W(IDX_W)) u_array (
    .clk(clk), .rst_n(rst_n), .prog(do_prog), .lock(do_lock), .dbl(ctrl.dbl),
    .idx(idx), .wdata(bus_wdata), .prim_word(prim_word), .red_word(red_word),
    .locked(locked)
  );

  otp_gate u_gate (
    .wr_win(wr_win), .rd_win(rd_win), .rng_err(rng_err), .rd_pwr(ctrl.rd_pwr),
    .check(ctrl.check), .lock_wr(ctrl.lock_wr), .supply(supply), .key_ok(key_ok),
    .blk_locked(locked), .cur_word(prim_word), .wdata(bus_wdata),
    .do_prog(do_prog), .do_lock(do_lock), .err_set(err_set)
  );

  always_comb begin
    if (!ctrl.dbl)        sensed_word = prim_word;
    else if (ctrl.margin) sensed_word = prim_word & red_word;
    else                  sensed_word = prim_word | red_word;
    win_word = (in_rng && ctrl.rd_pwr) ? sensed_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_req && !bus_we;
      if (bus_req && !bus_we) bus_rdata <= win_hit ? win_word : reg_rdata;
    end
  end

  // R9
  nopwr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && win_hit && !ctrl.rd_pwr) |=> (bus_rdata == '0));
  // R3
  prog_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_prog |-> (key_ok && supply.prog && supply.key1 && !supply.key2));
  // R10
  range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && win_hit && !in_rng) |=> err_q[E_RANGE]);
  // R1
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we) |=> bus_rvalid);
endmodule

// File: tb/tb_otp_fuse_ctrl.sv
module tb_otp_fuse_ctrl;
  localparam int unsigned NB = 12;
  localparam int unsigned AW = 13;
  localparam logic [AW-1:0] A_CTRL = 13'h0020, A_ERR = 13'h0024, A_CLR = 13'h0028,
                            A_KEY = 13'h002C, A_CFG = 13'h0050, A_SUP = 13'h0054;

  logic          clk = 1'b0, rst_n = 1'b0, bus_req = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0, bus_rdata;
  logic          bus_rvalid;
  int            checks = 0, fails = 0;
  bit            done = 1'b0;

  always #2 clk = ~clk;

  otp_fuse_ctrl #(.NUM_BLK(NB), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  function automatic logic [AW-1:0] wa(input int n);
    return AW'(32'h1000 + 4 * n);
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_req = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
    @(negedge clk); bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk); bus_req = 1'b0; d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic rchk(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d; logic v;
    rd(a, d, v);
    chk(d, exp, tag);
  endtask

  task automatic arm(input logic [31:0] sup);
    wr(A_KEY, 32'h0000_8810);
    wr(A_SUP, sup);
  endtask

  task automatic clr_all();
    wr(A_CLR, 32'h0000_3FFF);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    logic [31:0] d; logic v;
    do_reset();
    chk({31'b0, bus_rvalid}, 32'h0, "R1 rvalid after reset");
    rchk(A_CTRL, 32'h0, "R1 control reset");
    rchk(A_ERR, 32'h0, "R1 error reset");
    rchk(A_KEY, 32'h0, "R1 key reset");
    rchk(A_CFG, 32'h0, "R1 config reset");
    rd(A_SUP, d, v);
    chk(d, 32'h0, "R1 supply reset");
    chk({31'b0, v}, 32'h1, "R1 rvalid one cycle after read");
  endtask

  task automatic t_regmap();
    wr(A_CTRL, 32'hFFFF_FFFF); rchk(A_CTRL, 32'h1F, "R2 control width");
    wr(A_SUP, 32'hFFFF_FFFF);  rchk(A_SUP, 32'h7, "R2 supply width");
    wr(A_CFG, 32'hA5A5_1234);  rchk(A_CFG, 32'hA5A5_1234, "R2 config readback");
    wr(A_KEY, 32'h0000_8810);  rchk(A_KEY, 32'h0000_8810, "R2 key readback");
    rchk(A_CLR, 32'h0, "R11 clear offset reads zero");
    wr(A_CTRL, 32'h0); wr(A_SUP, 32'h0); wr(A_KEY, 32'h0);
  endtask

  task automatic t_gate();
    wr(A_CTRL, 32'h01); clr_all();
    wr(A_SUP, 32'h5); wr(wa(0), 32'h0F);
    rchk(A_ERR, 32'h1, "R3 no key flags bit0");
    rchk(wa(0), 32'h0, "R3 no key leaves word");
    clr_all();
    wr(A_KEY, 32'h0000_8810); wr(A_SUP, 32'h1); wr(wa(0), 32'h0F);
    rchk(A_ERR, 32'h1, "R3 no program enable flags bit0");
    rchk(wa(0), 32'h0, "R3 no program enable leaves word");
    clr_all();
    arm(32'h5);
    wr(wa(0), 32'h0F); wr(wa(0), 32'hF0); wr(wa(0), 32'h0);
    rchk(wa(0), 32'hFF, "R3 OR-only programming");
    rchk(A_ERR, 32'h0, "R3 good programs raise nothing");
  endtask

  task automatic t_supply();
    logic [31:0] bad [3] = '{32'h7, 32'h4, 32'h6};
    for (int i = 0; i < 3; i++) begin
      clr_all(); arm(bad[i]); wr(wa(1), 32'h3);
      rchk(A_ERR, 32'h2, "R4 bad key state flags bit1");
      rchk(wa(1), 32'h0, "R4 bad key state leaves word");
    end
    clr_all();
  endtask

  task automatic t_lock();
    arm(32'h5);
    wr(A_CTRL, 32'h11); wr(wa(2), 32'hDEAD);
    wr(A_CTRL, 32'h01);
    rchk(wa(2), 32'h0, "R5 lock write stores no data");
    rchk(A_ERR, 32'h0, "R5 lock raises nothing");
    wr(wa(2), 32'h1);
    rchk(A_ERR, 32'h4, "R5 locked word flags bit2");
    rchk(wa(2), 32'h0, "R5 locked word unchanged");
    clr_all();
    wr(wa(3), 32'h3); wr(A_CTRL, 32'h11); wr(wa(3), 32'h0); wr(A_CTRL, 32'h01);
    wr(wa(3), 32'h4);
    rchk(wa(3), 32'h3, "R5 locked after program");
    do_reset();
    rchk(A_CTRL, 32'h0, "R1 control cleared by mid-run reset");
    wr(A_CTRL, 32'h01);
    rchk(wa(3), 32'h3, "R5 fuse survives reset");
    arm(32'h5); wr(wa(2), 32'h8);
    rchk(A_ERR, 32'h4, "R5 lock survives reset");
    clr_all();
  endtask

  task automatic t_double();
    arm(32'h5);
    wr(A_CTRL, 32'h01); wr(wa(4), 32'h0F0);
    wr(A_CTRL, 32'h05); wr(wa(4), 32'hF00);
    rchk(wa(4), 32'hFF0, "R6 doubled read ORs copies");
    wr(A_CTRL, 32'h0D);
    rchk(wa(4), 32'hF00, "R7 margin read ANDs copies");
    wr(A_CTRL, 32'h09);
    rchk(wa(4), 32'hFF0, "R7 margin without doubling no effect");
    wr(A_CTRL, 32'h01);
    rchk(wa(4), 32'hFF0, "R6 plain read returns primary");
  endtask

  task automatic t_check();
    clr_all(); arm(32'h5);
    wr(A_CTRL, 32'h03); wr(wa(5), 32'h55);
    rchk(A_ERR, 32'h0, "R8 auto-check with power passes");
    wr(A_CTRL, 32'h02); wr(wa(6), 32'h0A);
    wr(A_CTRL, 32'h01);
    rchk(A_ERR, 32'h8, "R8 auto-check without power flags bit3");
    rchk(wa(6), 32'h0A, "R8 word programmed despite flag");
    clr_all();
  endtask

  task automatic t_nopwr();
    wr(A_CTRL, 32'h00);
    rchk(wa(5), 32'h0, "R9 unpowered read returns zero");
    rchk(A_ERR, 32'h10, "R9 unpowered read flags bit4");
    wr(A_CTRL, 32'h01); clr_all();
    rchk(wa(5), 32'h55, "R9 powered read returns data");
  endtask

  task automatic t_range();
    arm(32'h5); wr(A_CTRL, 32'h01); clr_all();
    wr(wa(NB - 1), 32'h7);
    rchk(wa(NB - 1), 32'h7, "R10 last word usable");
    rchk(A_ERR, 32'h0, "R10 last word no flag");
    wr(wa(NB), 32'hFF);
    rchk(A_ERR, 32'h20, "R10 write beyond flags bit5");
    clr_all();
    rchk(wa(NB), 32'h0, "R10 read beyond returns zero");
    rchk(A_ERR, 32'h20, "R10 read beyond flags bit5");
    rchk(wa(NB - 1), 32'h7, "R10 write beyond changed nothing");
    clr_all();
  endtask

  task automatic t_clear();
    wr(A_SUP, 32'h0); wr(wa(0), 32'h1); wr(wa(NB), 32'h1);
    rchk(A_ERR, 32'h21, "R11 two flags set");
    wr(A_CLR, 32'h1);
    rchk(A_ERR, 32'h20, "R11 mask clears only its bit");
    wr(A_CLR, 32'hFFFF_FFFF);
    rchk(A_ERR, 32'h0, "R11 full mask clears all");
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_regmap();
    t_gate();
    t_supply();
    t_lock();
    t_double();
    t_check();
    t_nopwr();
    t_range();
    t_clear();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule